// File: doc/BRIEF.md
# Storage-Area Chip-Enable and DMA Acknowledge Sequencer

This block drives the strobes for one local-bus area that holds an ATA-style storage card. It produces two active-low card chip enables and an active-low DMA acknowledge. The processor reaches the card's control and alternate-status registers through byte cycles and the data register through word cycles. The DMA engine moves the data port in bursts that the card requests with a level-sensitive request line. Each kind of access gets its own strobe pattern. During DMA both chip enables stay off, and the acknowledge alone marks the transfer.

A bus sequencer outside the block reports when each cycle ends. The block arbitrates between a pending processor cycle and the DMA request. It loads a burst length when a burst opens and counts down one step per DMA cycle end. When the burst-hold bit is set, it keeps the acknowledge low from the first DMA cycle to the last one, even if the request drops in between. When the bit is clear, the acknowledge is pulsed once per DMA cycle. The chip enables and the acknowledge are never active together.

Top module: `ata_strobe_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, ce1_n, ce2_n and dack_n are all 1.
- R2: A cpu_start pulse with cpu_word=0 (byte), accepted when no burst holds the bus, gives ce1_n=1, ce2_n=0, dack_n=1 from the next edge. This pattern holds until the edge that samples cyc_end, after which all outputs are 1.
- R3: A cpu_start pulse with cpu_word=1 (word) behaves as in R2 but gives ce1_n=0 and ce2_n=1.
- R4: While a DMA cycle runs, ce1_n=1 and ce2_n=1.
- R5: With no burst open and dreq high at an edge, dack_n goes to 0 from that edge and a burst of xfer_len cycles opens; a value of 0 is treated as 1. Each cyc_end during a DMA cycle ends that cycle. After the last cycle ends, dack_n returns to 1 and the burst closes.
- R6: In a burst opened with burst_hold=1, dack_n stays 0 between DMA cycles whatever dreq does, until the last cycle ends.
- R7: In a burst opened with burst_hold=0, dack_n is 1 between DMA cycles. A new DMA cycle starts at the first edge that sees dreq high.
- R8: A cpu_start that arrives while a DMA cycle runs, or while a hold burst is open, is kept and served once the bus is free. dack_n=0 never coincides with ce1_n=0 or ce2_n=0.
- R9: When a CPU request and dreq are both present while the bus is free, the CPU cycle goes first.
- R10: burst_hold and xfer_len are sampled only when a burst opens. Changing them mid-burst alters neither the hold behaviour nor the number of cycles.
- R11: cyc_end while no cycle runs has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_start | input | 1 | One-cycle pulse requesting a processor cycle |
| cpu_word | input | 1 | Width of the requested processor cycle: 1 word, 0 byte |
| cyc_end | input | 1 | One-cycle pulse marking the end of the running bus cycle |
| dreq | input | 1 | Level-sensitive DMA request |
| burst_hold | input | 1 | Keep the acknowledge low across the whole burst |
| xfer_len | input | CNT_W | Number of DMA cycles in the next burst |
| ce1_n | output | 1 | Active-low chip enable used by word cycles |
| ce2_n | output | 1 | Active-low chip enable used by byte cycles |
| dack_n | output | 1 | Active-low DMA acknowledge |

## Verification
The bench builds the block with CNT_W=4. This makes every burst length from the zero case up to the largest value, 15, reachable in short random runs. It also lets the counter empty many times, so bursts open and close repeatedly while CPU requests wait and dreq toggles. Directed phases cover burst lengths 4, 3, 2, 1 and 0, with both settings of the hold bit.

// File: rtl/ata_ce_pkg.sv
package ata_ce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CPU  = 2'd1,
        ST_DMA  = 2'd2
    } bus_st_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2_n;
        logic dack_n;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{ce1_n: 1'b1, ce2_n: 1'b1, dack_n: 1'b1};

    // Strobe pattern of a processor cycle: word cycles use enable 1, byte cycles enable 2.
    function automatic strobe_t cpu_strobe(input logic is_word);
        strobe_t s;
        s        = STROBE_OFF;
        s.ce1_n  = ~is_word;
        s.ce2_n  = is_word;
        return s;
    endfunction

    // Full output decode from the bus state that will hold after the edge.
    function automatic strobe_t strobe_decode(input bus_st_e st, input logic is_word,
                                              input logic burst_open, input logic hold);
        strobe_t s;
        s = STROBE_OFF;
        case (st)
            ST_CPU:  s = cpu_strobe(is_word);
            ST_DMA:  s.dack_n = 1'b0;
            default: s.dack_n = ~(burst_open & hold);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ata_cpu_pending.sv
module ata_cpu_pending (
    input  logic clk,
    input  logic rst,
    input  logic cpu_start,
    input  logic cpu_word,
    input  logic accept,
    output logic want,
    output logic want_word
);
    logic pend_q;
    logic pend_word_q;

    assign want      = pend_q | cpu_start;
    assign want_word = pend_q ? pend_word_q : cpu_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_word_q <= 1'b0;
        end else if (accept) begin
            pend_q      <= 1'b0;
        end else if (cpu_start && !pend_q) begin
            pend_q      <= 1'b1;
            pend_word_q <= cpu_word;
        end
    end

    // R8: a waiting request is not dropped before it is served
    a_r8_pending_kept: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !accept) |=> pend_q);

endmodule

// File: rtl/ata_xfer_counter.sv
module ata_xfer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             burst_open,
    output logic             open_nxt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt_q;
        if (load)
            cnt_nxt = (load_val == '0) ? ONE : load_val;
        else if (dec)
            cnt_nxt = cnt_q - ONE;
    end

    assign burst_open = (cnt_q != '0);
    assign open_nxt   = (cnt_nxt != '0);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end

    // R5: every DMA cycle end removes exactly one cycle from the burst
    a_r5_dec_step: assert property (@(posedge clk) disable iff (rst)
        dec |=> cnt_q == $past(cnt_q) - ONE);
    // R5: no DMA cycle runs on an empty burst
    a_r5_no_dec_empty: assert property (@(posedge clk) disable iff (rst)
        dec |-> cnt_q != '0);
    // R10: a burst length is only taken while no burst is open
    a_r10_load_when_closed: assert property (@(posedge clk) disable iff (rst)
        load |-> cnt_q == '0);

endmodule

// File: rtl/ata_bus_fsm.sv
module ata_bus_fsm
    import ata_ce_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    want,
    input  logic    want_word,
    input  logic    dreq,
    input  logic    cyc_end,
    input  logic    burst_hold,
    input  logic    burst_open,
    output logic    accept,
    output logic    load,
    output logic    dec,
    output bus_st_e st_q,
    output bus_st_e st_nxt,
    output logic    word_nxt,
    output logic    hold_q,
    output logic    hold_nxt
);
    logic    word_q;
    logic    cpu_ok;
    logic    start_dma;

    always_comb begin
        cpu_ok    = want && !(burst_open && hold_q);
        accept    = (st_q == ST_IDLE) && cpu_ok;
        start_dma = (st_q == ST_IDLE) && !cpu_ok && dreq;
        load      = start_dma && !burst_open;
        dec       = (st_q == ST_DMA) && cyc_end;
        st_nxt    = st_q;
        case (st_q)
            ST_IDLE: begin
                if (accept)         st_nxt = ST_CPU;
                else if (start_dma) st_nxt = ST_DMA;
            end
            ST_CPU:  if (cyc_end) st_nxt = ST_IDLE;
            ST_DMA:  if (cyc_end) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
        word_nxt = accept ? want_word : word_q;
        hold_nxt = load ? burst_hold : hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            word_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            word_q <= word_nxt;
            hold_q <= hold_nxt;
        end
    end

    // R9: a CPU request seen with a free bus and no hold burst is taken before DMA
    a_r9_cpu_first: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && want && !burst_open) |=> st_q == ST_CPU);
    // R10: the hold setting is frozen while a burst is open
    a_r10_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (burst_open && $past(burst_open)) |-> $stable(hold_q));

endmodule

// File: rtl/ata_strobe_reg.sv
module ata_strobe_reg
    import ata_ce_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_st_e st_nxt,
    input  logic    word_nxt,
    input  logic    open_nxt,
    input  logic    hold_nxt,
    output logic    ce1_n,
    output logic    ce2_n,
    output logic    dack_n
);
    strobe_t out_q;

    always_ff @(posedge clk) begin
        if (rst) out_q <= STROBE_OFF;
        else     out_q <= strobe_decode(st_nxt, word_nxt, open_nxt, hold_nxt);
    end

    assign ce1_n  = out_q.ce1_n;
    assign ce2_n  = out_q.ce2_n;
    assign dack_n = out_q.dack_n;

    // R1: outputs are inactive on the cycle after reset
    a_r1_reset_off: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ce1_n && ce2_n && dack_n));
    // R2 / R3: at most one chip enable is active
    a_r2_ce_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~ce1_n, ~ce2_n}));

endmodule

// File: rtl/ata_strobe_ctrl.sv
module ata_strobe_ctrl
    import ata_ce_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_start,
    input  logic             cpu_word,
    input  logic             cyc_end,
    input  logic             dreq,
    input  logic             burst_hold,
    input  logic [CNT_W-1:0] xfer_len,
    output logic             ce1_n,
    output logic             ce2_n,
    output logic             dack_n
);
    logic    want, want_word, accept, load, dec;
    logic    burst_open, open_nxt, word_nxt, hold_q, hold_nxt;
    bus_st_e st_q, st_nxt;

    ata_cpu_pending u_pend (
        .clk(clk), .rst(rst), .cpu_start(cpu_start), .cpu_word(cpu_word),
        .accept(accept), .want(want), .want_word(want_word)
    );

    ata_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(xfer_len), .dec(dec),
        .burst_open(burst_open), .open_nxt(open_nxt)
    );

    ata_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .want(want), .want_word(want_word), .dreq(dreq),
        .cyc_end(cyc_end), .burst_hold(burst_hold), .burst_open(burst_open),
        .accept(accept), .load(load), .dec(dec), .st_q(st_q), .st_nxt(st_nxt),
        .word_nxt(word_nxt), .hold_q(hold_q), .hold_nxt(hold_nxt)
    );

    ata_strobe_reg u_out (
        .clk(clk), .rst(rst), .st_nxt(st_nxt), .word_nxt(word_nxt),
        .open_nxt(open_nxt), .hold_nxt(hold_nxt),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .dack_n(dack_n)
    );

    // R4: both enables stay off while a DMA cycle runs
    a_r4_dma_no_ce: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DMA) |-> (ce1_n && ce2_n));
    // R8: acknowledge and chip enables never overlap
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !dack_n |-> (ce1_n && ce2_n));
    // R6: in a hold burst the acknowledge stays low until the burst closes
    a_r6_hold_keeps_dack: assert property (@(posedge clk) disable iff (rst)
        (!dack_n && burst_open && hold_q) |=> (!dack_n || !burst_open));
    // R7: without hold the acknowledge is released after each DMA cycle
    a_r7_gap_release: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && st_q == ST_DMA && cyc_end) |=> dack_n);

endmodule

// File: tb/ata_strobe_ctrl_tb.sv
module ata_strobe_ctrl_tb_top;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cpu_start = 1'b0, cpu_word = 1'b0, cyc_end = 1'b0;
    logic             dreq = 1'b0, burst_hold = 1'b0;
    logic [CNT_W-1:0] xfer_len = '0;
    logic             ce1_n, ce2_n, dack_n;

    int    errors = 0, checks = 0, wd = 0;
    string scen = "R1";

    // model state: 0 free, 1 processor cycle, 2 DMA cycle
    int m_st = 0, m_cnt = 0;
    bit m_word = 0, m_pend = 0, m_pword = 0, m_hold = 0;

    always #10 clk = ~clk;

    ata_strobe_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .cpu_start(cpu_start), .cpu_word(cpu_word),
        .cyc_end(cyc_end), .dreq(dreq), .burst_hold(burst_hold), .xfer_len(xfer_len),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .dack_n(dack_n)
    );

    function automatic bit [2:0] exp_out(int st, bit w, int cnt, bit hold);
        bit c1, c2, dk;
        c1 = !(st == 1 && w);
        c2 = !(st == 1 && !w);
        dk = !(st == 2 || (st == 0 && cnt != 0 && hold));
        return {c1, c2, dk};
    endfunction

    function automatic string tag_of(int st, bit w, int cnt, bit hold);
        if (st == 1) return w ? "R3" : "R2";
        if (st == 2) return "R4";
        if (cnt != 0) return hold ? "R6" : "R7";
        return "R11";
    endfunction

    always @(posedge clk) begin
        bit want, ww, open, acc;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_word = 0; m_pend = 0; m_pword = 0; m_hold = 0;
        end else begin
            want = m_pend || cpu_start;
            ww   = m_pend ? m_pword : cpu_word;
            open = (m_cnt != 0);
            acc  = 0;
            case (m_st)
                0: if (want && !(open && m_hold)) begin
                       m_st = 1; m_word = ww; acc = 1;
                   end else if (dreq) begin
                       if (!open) begin
                           m_cnt  = (xfer_len == 0) ? 1 : int'(xfer_len);
                           m_hold = burst_hold;
                       end
                       m_st = 2;
                   end
                1: if (cyc_end) m_st = 0;
                2: if (cyc_end) begin m_cnt = m_cnt - 1; m_st = 0; end
                default: m_st = 0;
            endcase
            if (acc) m_pend = 0;
            else if (cpu_start && !m_pend) begin m_pend = 1; m_pword = cpu_word; end
        end
    end

    always @(negedge clk) begin
        bit [2:0] e, a;
        string t;
        e = exp_out(m_st, m_word, m_cnt, m_hold);
        a = {ce1_n, ce2_n, dack_n};
        t = (scen != "") ? scen : tag_of(m_st, m_word, m_cnt, m_hold);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s at %0t: {ce1_n,ce2_n,dack_n} actual=%b expected=%b", t, $time, a, e);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_end();
        cyc_end = 1'b1; tick(1); cyc_end = 1'b0;
    endtask

    task automatic pulse_cpu(bit w);
        cpu_word = w; cpu_start = 1'b1; tick(1); cpu_start = 1'b0;
    endtask

    task automatic dma_cycle(int wait_n);
        dreq = 1'b1; tick(2); dreq = 1'b0; tick(wait_n); pulse_end(); tick(2);
    endtask

    initial begin
        void'($urandom(32'd4711));
        tick(3);
        rst = 1'b0;
        tick(2);

        scen = "R2"; pulse_cpu(1'b0); tick(3); pulse_end(); tick(2);
        scen = "R3"; pulse_cpu(1'b1); tick(2); pulse_end(); tick(2);

        scen = "R6"; burst_hold = 1'b1; xfer_len = 4'd4;
        for (int i = 0; i < 4; i++) dma_cycle(1);
        scen = "R7"; burst_hold = 1'b0; xfer_len = 4'd3;
        for (int i = 0; i < 3; i++) dma_cycle(2);

        scen = "R8"; burst_hold = 1'b1; xfer_len = 4'd2; dreq = 1'b1; tick(1);
        pulse_cpu(1'b1); dreq = 1'b0; tick(1); pulse_end(); tick(3);
        dreq = 1'b1; tick(1); dreq = 1'b0; pulse_end(); tick(2); pulse_end(); tick(2);
        burst_hold = 1'b0; dreq = 1'b1; tick(1); pulse_cpu(1'b0); dreq = 1'b0;
        pulse_end(); tick(1); pulse_end(); tick(1); dma_cycle(0); tick(2);

        scen = "R9"; xfer_len = 4'd1; dreq = 1'b1; pulse_cpu(1'b1); tick(2);
        pulse_end(); tick(2); dreq = 1'b0; pulse_end(); tick(2);

        scen = "R10"; burst_hold = 1'b1; xfer_len = 4'd2; dreq = 1'b1; tick(1);
        burst_hold = 1'b0; xfer_len = 4'd7; dreq = 1'b0; tick(1); pulse_end(); tick(3);
        dma_cycle(1); tick(2);

        scen = "R11"; pulse_end(); tick(1); pulse_end(); tick(2);
        scen = "R5"; xfer_len = 4'd0; dreq = 1'b1; tick(1); dreq = 1'b0; pulse_end(); tick(3);

        scen = "";
        for (int i = 0; i < 5000; i++) begin
            cpu_start  = ($urandom % 9) == 0;
            cpu_word   = $urandom % 2;
            cyc_end    = ($urandom % 4) == 0;
            burst_hold = $urandom % 2;
            xfer_len   = CNT_W'($urandom);
            if (($urandom % 5) == 0) dreq = ~dreq;
            tick(1);
        end
        cpu_start = 1'b0; cyc_end = 1'b0; dreq = 1'b0;
        tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule